// File: doc/BRIEF.md
# Zero-Flagged Coefficient Buffer

This block sits between a quantizer and a variable-length coder and holds one block of quantized coefficients. Because most quantized values are zero, the coefficients are packed four at a time into memory words, and a single marker bit is kept for each group of four. When a group is entirely zero only its marker is recorded and the memory is not written; on the way out, a marked group is replaced by four zeros without reading the memory.

Coefficients enter through a valid/ready write port in coding order and leave through a valid/ready read port in the same order. Once a full block has been written the write port stalls until every coefficient has been read. Two counters report how many memory writes and memory reads the current block really caused, so the savings can be measured against the number of non-zero groups.

Top module: `zfb_top`

## Requirements
- R1: After a synchronous reset, wr_ready is 1, rd_valid is 0, blk_full is 0 and both activity counters read 0.
- R2: A coefficient is accepted on a clock edge where wr_valid and wr_ready are both 1; after the 64th accepted coefficient blk_full becomes 1 and wr_ready stays 0 until the block is drained, so inputs offered meanwhile are not taken.
- R3: A group (coefficients 4g to 4g+3) whose four values are all zero causes no memory write; after a block is written, mem_wr_count equals the number of groups holding at least one non-zero coefficient.
- R4: The read port returns the 64 coefficients in exactly the order and with the exact signed 12-bit values that were written, with zeros for all-zero groups.
- R5: A memory read is issued only for groups with a non-zero value, one cycle before that group's first coefficient is presented; after a block is drained mem_rd_count equals the number of non-zero groups.
- R6: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_coef stays unchanged on the next cycle.
- R7: The edge that takes the 64th read clears blk_full and raises wr_ready; both counters keep their values until the first coefficient of the next block is accepted, which clears them to 0.
- R8: With rd_ready held at 1, the read port delivers the block without a gap: from the first read handshake to the last, rd_valid is 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write coefficient offered |
| wr_coef | input | 12 | Signed quantized coefficient to store |
| wr_ready | output | 1 | Buffer can accept a coefficient |
| rd_ready | input | 1 | Consumer takes the presented coefficient |
| rd_valid | output | 1 | A coefficient is presented |
| rd_coef | output | 12 | Signed coefficient presented to the coder |
| blk_full | output | 1 | A complete block is held and not yet drained |
| mem_wr_count | output | 5 | Memory writes issued for the current block |
| mem_rd_count | output | 5 | Memory reads issued for the current block |

## Verification
The two functions that share a cycle are the hand-off of the last coefficient of one group and the lookup of the next group, either a memory read or a marker-driven zero fill. Holding rd_ready at 1 forces them together on every group boundary, and the result is judged by a scoreboard that compares every returned value in order and by counting cycles without rd_valid between the first and last read handshake, which must be none. Stalled and irregular rd_ready patterns then move the boundary to different cycles, with mixed zero and non-zero groups so both kinds of lookup land on it, and the memory-read counter is compared with the non-zero group count.

// File: rtl/zfb_pkg.sv
package zfb_pkg;
    parameter int COEF_W = 12;
    parameter int GRP    = 4;
    parameter int NCOEF  = 64;

    localparam int NGRP   = NCOEF / GRP;
    localparam int WORD_W = COEF_W * GRP;
    localparam int IDX_W  = $clog2(NCOEF);
    localparam int SUB_W  = $clog2(GRP);
    localparam int GIDX_W = $clog2(NGRP);
    localparam int CNT_W  = $clog2(NGRP + 1);

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic [IDX_W-1:0]  wcnt;
        logic [NGRP-1:0]   mark;
        logic              full;
        logic [GIDX_W:0]   ig;
        logic [IDX_W-1:0]  rcnt;
        logic              act;
        logic              zsrc;
        cnt_t              wr_n;
        cnt_t              rd_n;
    } ctl_t;
endpackage

// File: rtl/zfb_mem.sv
module zfb_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 48,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/zfb_pack.sv
module zfb_pack
    import zfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [SUB_W-1:0] sub,
    input  coef_t            coef,
    output word_t            word,
    output logic             all_zero
);
    logic [GRP-2:0][COEF_W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        for (int i = 0; i < GRP - 1; i++) begin
            if (accept && sub == SUB_W'(i)) begin
                stage_d[i] = coef;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign word     = {coef, stage_q};
    assign all_zero = (word == '0);
endmodule

// File: rtl/zfb_lane_sel.sv
module zfb_lane_sel
    import zfb_pkg::*;
(
    input  word_t            word,
    input  logic [SUB_W-1:0] sub,
    input  logic             zero_src,
    output coef_t            coef
);
    coef_t lanes [GRP];

    for (genvar g = 0; g < GRP; g++) begin : g_lane
        assign lanes[g] = word[g*COEF_W +: COEF_W];
    end

    assign coef = zero_src ? '0 : lanes[sub];
endmodule

// File: rtl/zfb_top.sv
module zfb_top
    import zfb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_valid,
    input  coef_t wr_coef,
    output logic  wr_ready,
    input  logic  rd_ready,
    output logic  rd_valid,
    output coef_t rd_coef,
    output logic  blk_full,
    output cnt_t  mem_wr_count,
    output cnt_t  mem_rd_count
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NCOEF - 1);
    localparam logic [SUB_W-1:0]  LAST_SUB = SUB_W'(GRP - 1);
    localparam logic [GIDX_W:0]   GRP_END  = (GIDX_W + 1)'(NGRP);

    ctl_t q, d;

    logic               wr_hs, rd_hs, grp_done, issue;
    logic               mem_we, mem_re;
    logic [SUB_W-1:0]   wsub, rsub;
    logic [GIDX_W-1:0]  wgrp, igrp;
    word_t              pack_word, mem_rdata;
    logic               pack_zero;

    assign wsub = q.wcnt[SUB_W-1:0];
    assign wgrp = q.wcnt[IDX_W-1:SUB_W];
    assign rsub = q.rcnt[SUB_W-1:0];
    assign igrp = q.ig[GIDX_W-1:0];

    zfb_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .accept   (wr_hs),
        .sub      (wsub),
        .coef     (wr_coef),
        .word     (pack_word),
        .all_zero (pack_zero)
    );

    zfb_mem #(.DEPTH(NGRP), .WIDTH(WORD_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (wgrp),
        .wdata (pack_word),
        .re    (mem_re),
        .raddr (igrp),
        .rdata (mem_rdata)
    );

    zfb_lane_sel u_sel (
        .word     (mem_rdata),
        .sub      (rsub),
        .zero_src (q.zsrc),
        .coef     (rd_coef)
    );

    always_comb begin
        wr_hs    = wr_valid && !q.full;
        grp_done = wr_hs && (wsub == LAST_SUB);
        mem_we   = grp_done && !pack_zero;

        rd_hs    = q.act && rd_ready;
        issue    = q.full && (q.ig < GRP_END) &&
                   (!q.act || (rd_hs && rsub == LAST_SUB));
        mem_re   = issue && !q.mark[igrp];

        d = q;

        // write side
        if (wr_hs) begin
            if (q.wcnt == '0) begin
                d.wr_n = '0;
                d.rd_n = '0;
            end
            if (grp_done) begin
                d.mark[wgrp] = pack_zero;
                if (!pack_zero) begin
                    d.wr_n = d.wr_n + CNT_W'(1);
                end
            end
            if (q.wcnt == LAST_IDX) begin
                d.wcnt = '0;
                d.full = 1'b1;
            end else begin
                d.wcnt = q.wcnt + IDX_W'(1);
            end
        end

        // read side: delivery
        if (rd_hs) begin
            d.rcnt = q.rcnt + IDX_W'(1);
            if (rsub == LAST_SUB) begin
                d.act = 1'b0;
            end
            if (q.rcnt == LAST_IDX) begin
                d.full = 1'b0;
                d.ig   = '0;
                d.rcnt = '0;
            end
        end

        // read side: group lookup, may coincide with the last delivery of a group
        if (issue) begin
            d.act  = 1'b1;
            d.ig   = q.ig + (GIDX_W + 1)'(1);
            d.zsrc = q.mark[igrp];
            if (mem_re) begin
                d.rd_n = q.rd_n + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_ready     = !q.full;
    assign rd_valid     = q.act;
    assign blk_full     = q.full;
    assign mem_wr_count = q.wr_n;
    assign mem_rd_count = q.rd_n;
endmodule

// File: rtl/zfb_chk.sv
module zfb_chk
    import zfb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  mem_we,
    input logic  mem_re,
    input logic  rd_valid,
    input logic  rd_ready,
    input coef_t rd_coef,
    input logic  blk_full,
    input cnt_t  mem_wr_count,
    input cnt_t  mem_rd_count
);
    localparam cnt_t CNT_MAX = CNT_W'(NGRP);

    // R3: no memory write once the block is complete
    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !blk_full);

    // R3: write counter bounded by group count
    a_r3_wr_count_bound: assert property (@(posedge clk) disable iff (rst)
        mem_wr_count <= CNT_MAX);

    // R5: read counter bounded by group count
    a_r5_rd_count_bound: assert property (@(posedge clk) disable iff (rst)
        mem_rd_count <= CNT_MAX);

    // R5: memory is never read and written in one cycle
    a_r5_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R5: a memory read is followed by a presented coefficient
    a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> rd_valid);

    // R7: coefficients are presented only while a block is held
    a_r7_read_needs_full: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> blk_full);

    // R6: backpressure holds the presented coefficient
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_coef)));
endmodule

bind zfb_top zfb_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_coef      (rd_coef),
    .blk_full     (blk_full),
    .mem_wr_count (mem_wr_count),
    .mem_rd_count (mem_rd_count)
);

// File: tb/tb_zfb_top.sv
module tb_zfb_top;
    import zfb_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  wr_valid = 1'b0;
    coef_t wr_coef = '0;
    logic  wr_ready;
    logic  rd_ready = 1'b0;
    logic  rd_valid;
    coef_t rd_coef;
    logic  blk_full;
    cnt_t  mem_wr_count, mem_rd_count;

    int vecs = 0;
    int errs = 0;
    coef_t exp_q [$];

    always #10 clk = ~clk;

    zfb_top dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_coef(wr_coef), .wr_ready(wr_ready),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_coef(rd_coef),
        .blk_full(blk_full),
        .mem_wr_count(mem_wr_count), .mem_rd_count(mem_rd_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic coef_t gen(input int pat, input int i);
        int g = i / 4;
        int l = i % 4;
        case (pat)
            0: return '0;
            1: begin
                if (i == 0)  return coef_t'(-2048);
                if (i == 63) return coef_t'(2047);
                return coef_t'(((i * 37 + 5) % 4095) - 2047);
            end
            2: begin
                if ((g % 2) == 0 && l == ((g / 2) % 4)) return coef_t'(g * 100 - 700);
                return '0;
            end
            3: return (i == 63) ? coef_t'(-1) : '0;
            default: return (l == 0 && g != 0) ? coef_t'(g) : '0;
        endcase
    endfunction

    function automatic int nz_groups(input int pat);
        int n = 0;
        for (int g = 0; g < NGRP; g++) begin
            bit any = 0;
            for (int l = 0; l < GRP; l++) begin
                if (gen(pat, g * GRP + l) != '0) any = 1;
            end
            if (any) n++;
        end
        return n;
    endfunction

    task automatic write_block(input int pat, input bit gaps, input bit chk_clear);
        int nz = nz_groups(pat);
        for (int i = 0; i < NCOEF; i++) begin
            coef_t v = gen(pat, i);
            bit acc = 0;
            exp_q.push_back(v);
            if (gaps && (i % 5) == 4) begin
                @(negedge clk);
                wr_valid = 1'b0;
            end
            while (!acc) begin
                @(negedge clk);
                wr_valid = 1'b1;
                wr_coef  = v;
                #1 acc = wr_ready;
                @(posedge clk);
            end
            if (i == 0 && chk_clear) begin
                @(negedge clk);
                wr_valid = 1'b0;
                #1;
                chk(mem_wr_count == '0, "R7 wr count cleared", int'(mem_wr_count), 0);
                chk(mem_rd_count == '0, "R7 rd count cleared", int'(mem_rd_count), 0);
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        chk(blk_full == 1'b1, "R2 full after 64", int'(blk_full), 1);
        chk(wr_ready == 1'b0, "R2 ready low when full", int'(wr_ready), 0);
        chk(int'(mem_wr_count) == nz, "R3 memory writes", int'(mem_wr_count), nz);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_coef  = 12'h555;
            #1 chk(wr_ready == 1'b0, "R2 stall while full", int'(wr_ready), 0);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic read_block(input int mode, input int nz);
        int popped = 0;
        int bubbles = 0;
        int cyc = 0;
        bit started = 0;
        bit prev_stall = 0;
        coef_t prev_val = '0;
        logic [7:0] lf = 8'h5a;
        while (popped < NCOEF) begin
            @(negedge clk);
            cyc++;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            case (mode)
                0: rd_ready = 1'b1;
                1: rd_ready = (cyc % 3) != 0;
                default: rd_ready = lf[0];
            endcase
            #1;
            if (prev_stall) begin
                chk(rd_valid == 1'b1, "R6 valid held", int'(rd_valid), 1);
                chk(rd_coef == prev_val, "R6 data held", int'($signed(rd_coef)), int'($signed(prev_val)));
            end
            if (mode == 0 && started && !rd_valid) bubbles++;
            prev_stall = rd_valid && !rd_ready;
            prev_val   = rd_coef;
            if (rd_valid && rd_ready) begin
                coef_t e = '0;
                if (exp_q.size() > 0) e = exp_q.pop_front();
                chk(rd_coef == e, "R4 coefficient", int'($signed(rd_coef)), int'($signed(e)));
                started = 1;
                popped++;
            end
        end
        @(negedge clk);
        rd_ready = 1'b0;
        #1;
        chk(blk_full == 1'b0, "R7 full cleared", int'(blk_full), 0);
        chk(wr_ready == 1'b1, "R7 ready back", int'(wr_ready), 1);
        chk(rd_valid == 1'b0, "R4 no extra data", int'(rd_valid), 0);
        chk(int'(mem_rd_count) == nz, "R5 memory reads", int'(mem_rd_count), nz);
        if (mode == 0) chk(bubbles == 0, "R8 gap-free stream", bubbles, 0);
    endtask

    task automatic run_block(input int pat, input int mode, input bit gaps, input bit clr);
        int nz = nz_groups(pat);
        fork
            write_block(pat, gaps, clr);
            read_block(mode, nz);
        join
        repeat (3) @(negedge clk);
        #1;
        chk(int'(mem_wr_count) == nz, "R7 wr count kept", int'(mem_wr_count), nz);
        chk(int'(mem_rd_count) == nz, "R7 rd count kept", int'(mem_rd_count), nz);
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        chk(blk_full == 1'b0, "R1 blk_full", int'(blk_full), 0);
        chk(mem_wr_count == '0, "R1 wr count", int'(mem_wr_count), 0);
        chk(mem_rd_count == '0, "R1 rd count", int'(mem_rd_count), 0);
        run_block(1, 0, 1'b0, 1'b0);
        run_block(0, 1, 1'b0, 1'b1);
        run_block(2, 2, 1'b1, 1'b1);
        run_block(3, 0, 1'b0, 1'b1);
        run_block(2, 0, 1'b0, 1'b1);
        run_block(4, 1, 1'b1, 1'b1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule